// File: doc/BRIEF.md
# Overload Auto-Restart and Soft-Start Controller

This block governs a switching regulator's fault response and its per-cycle peak-current ceiling. A strobe marks the start of each switching cycle. With that strobe comes a flag saying whether the previous cycle's peak current reached the ceiling. An up/down integrating counter adds one for every cycle that hit the ceiling and takes one away for every cycle that did not. Short, scattered bursts of limiting therefore fade away. Sustained limiting trips the counter, which removes the switching enable for a fixed restart wait. The controller then tries again.

Every start attempt, whether at reset or after a restart wait, ramps the 8-bit ceiling code linearly from a low seed up to full scale. Full scale stands for the default limit. While a light-load burst flag is set, the code is clamped to a reduced value. That value is scaled from full scale by the ratio of the burst current to the default current. When the supply clamp is overdriven at the same time as the peak current sits at the ceiling, the controller latches an open-loop fault. This fault stops switching until reset, which stands for a power cycle. One internal free-running time base paces both the restart wait and the ramp.

Top module: `ovr_guard`

## Requirements
- R1: On each accepted cycle strobe the overload count rises by one when `pk_at_lim` is 1 and falls by one when it is 0; it never goes below zero, so after k hits and m misses the count is max(k-m,0).
- R2: The strobe that brings the count to `TRIP_CYCLES` drives `sw_en` to 0 at the next clock edge and clears the count.
- R3: After a trip, `sw_en` stays 0 for `RESTART_TICKS` time-base ticks, which is between (RESTART_TICKS-1)*TICK_DIV+1 and RESTART_TICKS*TICK_DIV clocks, and then returns to 1.
- R4: Cycle strobes that arrive while switching is disabled do not move the overload count; after a restart a full `TRIP_CYCLES` hits are needed to trip again.
- R5: At reset and at every restart the code starts at `SS_MIN_CODE`. It rises by `SS_INC` every `SS_TICKS_PER_STEP` ticks, saturates at 2^CODE_W-1, and is held at `SS_MIN_CODE` while switching is disabled.
- R6: While `burst_mode` is 1, `ilim_code` equals the smaller of the ramp code and floor((2^CODE_W-1)*BURST_MA/FULL_MA).
- R7: `olp_fault` is set only by a cycle strobe with `pk_at_lim` and `clamp_over` both 1. Once set, it stays 1 and holds `sw_en` at 0 until `rst`. Neither input alone, nor `clamp_over` without a strobe, sets it.
- R8: During and right after synchronous reset, `sw_en` is 1, `ilim_code` is `SS_MIN_CODE` and `olp_fault` is 0.
- R9: `ilim_code` is registered: a change of `burst_mode` shows on `ilim_code` one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (supply power cycle) |
| cyc_start | input | 1 | One-clock strobe at the start of each switching cycle |
| pk_at_lim | input | 1 | Previous cycle's peak current reached the ceiling (valid with strobe) |
| burst_mode | input | 1 | Light-load burst operation active |
| clamp_over | input | 1 | Supply clamp current above its threshold |
| sw_en | output | 1 | Switching permitted |
| ilim_code | output | CODE_W | Peak-current ceiling code for the DAC |
| olp_fault | output | 1 | Latched open-loop fault |

## Verification
The hardest thing to show from the ports is the decay of the integrating counter. The count itself is never visible; only the moment of a trip is. The stimulus therefore sweeps every combination of k limit hits followed by m clean cycles in a small configuration. It then counts how many further hits are needed to drop `sw_en`, and compares that count with `TRIP_CYCLES - max(k-m,0)`. Each trip's restart wait is filled with limit-hit strobes. As a result, the next sweep step also shows that those strobes left the counter untouched.

// File: rtl/ovr_pkg.sv
package ovr_pkg;

  typedef enum logic [0:0] {
    PH_RUN  = 1'b0,
    PH_WAIT = 1'b1
  } phase_t;

  // width needed to hold values 0..n
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/ovr_tick_gen.sv
module ovr_tick_gen #(
  parameter int TICK_DIV = 500
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int DW = ovr_pkg::cnt_width(TICK_DIV);

  generate
    if (TICK_DIV <= 1) begin : g_every
      always_ff @(posedge clk) begin
        tick <= !rst;
      end
    end else begin : g_div
      localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          div_q <= '0;
          tick  <= 1'b0;
        end else if (div_q == LAST) begin
          div_q <= '0;
          tick  <= 1'b1;
        end else begin
          div_q <= div_q + 1'b1;
          tick  <= 1'b0;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/ovr_integrator.sv
module ovr_integrator #(
  parameter int TRIP_CYCLES = 3000,
  parameter int CW          = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          hit,
  output logic [CW-1:0] cnt,
  output logic          trip
);
  localparam logic [CW-1:0] LAST = CW'(TRIP_CYCLES - 1);

  assign trip = step && hit && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || trip) begin
      cnt <= '0;
    end else if (step) begin
      if (hit)
        cnt <= cnt + 1'b1;
      else if (cnt != '0)
        cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/ovr_ramp.sv
module ovr_ramp #(
  parameter int CODE_W            = 8,
  parameter int SS_MIN_CODE       = 42,
  parameter int SS_INC            = 1,
  parameter int SS_TICKS_PER_STEP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              tick,
  output logic [CODE_W-1:0] code
);
  localparam int DW = ovr_pkg::cnt_width(SS_TICKS_PER_STEP);
  localparam logic [DW-1:0]     DLAST = DW'(SS_TICKS_PER_STEP - 1);
  localparam logic [CODE_W:0]   TOP   = {1'b0, {CODE_W{1'b1}}};
  localparam logic [CODE_W:0]   INC   = (CODE_W + 1)'(SS_INC);
  localparam logic [CODE_W-1:0] SEED  = CODE_W'(SS_MIN_CODE);

  logic [DW-1:0]   div_q;
  logic [CODE_W:0] sum;

  assign sum = {1'b0, code} + INC;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      div_q <= '0;
      code  <= SEED;
    end else if (tick) begin
      if (div_q == DLAST) begin
        div_q <= '0;
        code  <= (sum > TOP) ? TOP[CODE_W-1:0] : sum[CODE_W-1:0];
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ovr_guard.sv
module ovr_guard #(
  parameter int TRIP_CYCLES       = 3000,
  parameter int TICK_DIV          = 500,
  parameter int RESTART_TICKS     = 100000,
  parameter int CODE_W            = 8,
  parameter int SS_MIN_CODE       = 42,
  parameter int SS_INC            = 1,
  parameter int SS_TICKS_PER_STEP = 4,
  parameter int FULL_MA           = 400,
  parameter int BURST_MA          = 85
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_start,
  input  logic              pk_at_lim,
  input  logic              burst_mode,
  input  logic              clamp_over,
  output logic              sw_en,
  output logic [CODE_W-1:0] ilim_code,
  output logic              olp_fault
);
  import ovr_pkg::*;

  localparam int CNT_W      = cnt_width(TRIP_CYCLES);
  localparam int HOLD_W     = cnt_width(RESTART_TICKS);
  localparam int FULL_CODE  = (1 << CODE_W) - 1;
  localparam int BURST_CODE = FULL_CODE * BURST_MA / FULL_MA;
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(RESTART_TICKS - 1);
  localparam logic [CODE_W-1:0] BURST_C   = CODE_W'(BURST_CODE);
  localparam logic [CODE_W-1:0] SEED_C    = CODE_W'(SS_MIN_CODE);

  phase_t            phase, nxt_phase;
  logic [HOLD_W-1:0] hold_cnt;
  logic              tick;
  logic              step, trip, hold_done, olp_set;
  logic [CNT_W-1:0]  ovl_cnt;
  logic [CODE_W-1:0] ss_code;

  ovr_tick_gen #(.TICK_DIV(TICK_DIV)) tick_i (
    .clk(clk), .rst(rst), .tick(tick)
  );

  assign step    = cyc_start && (phase == PH_RUN) && !olp_fault;
  assign olp_set = step && pk_at_lim && clamp_over;

  ovr_integrator #(.TRIP_CYCLES(TRIP_CYCLES), .CW(CNT_W)) integ_i (
    .clk(clk), .rst(rst), .step(step), .hit(pk_at_lim),
    .cnt(ovl_cnt), .trip(trip)
  );

  ovr_ramp #(
    .CODE_W(CODE_W), .SS_MIN_CODE(SS_MIN_CODE), .SS_INC(SS_INC),
    .SS_TICKS_PER_STEP(SS_TICKS_PER_STEP)
  ) ramp_i (
    .clk(clk), .rst(rst), .hold((phase == PH_WAIT) || olp_fault),
    .tick(tick), .code(ss_code)
  );

  assign hold_done = (phase == PH_WAIT) && tick && (hold_cnt == HOLD_LAST);

  always_comb begin
    nxt_phase = phase;
    if (trip)
      nxt_phase = PH_WAIT;
    else if (hold_done)
      nxt_phase = PH_RUN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_RUN;
      hold_cnt  <= '0;
      sw_en     <= 1'b1;
      olp_fault <= 1'b0;
      ilim_code <= SEED_C;
    end else begin
      phase <= nxt_phase;
      if (phase == PH_RUN)
        hold_cnt <= '0;
      else if (tick)
        hold_cnt <= hold_cnt + 1'b1;
      if (olp_set)
        olp_fault <= 1'b1;
      sw_en     <= (nxt_phase == PH_RUN) && !olp_fault && !olp_set;
      ilim_code <= (burst_mode && (ss_code > BURST_C)) ? BURST_C : ss_code;
    end
  end
endmodule

module ovr_guard_chk #(
  parameter int CNT_W       = 12,
  parameter int CODE_W      = 8,
  parameter int TRIP_CYCLES = 3000,
  parameter int BURST_CODE  = 54,
  parameter int SS_MIN_CODE = 42
) (
  input logic              clk,
  input logic              rst,
  input logic              cyc_start,
  input logic              pk_at_lim,
  input logic              burst_mode,
  input logic              clamp_over,
  input logic              sw_en,
  input logic              olp_fault,
  input logic [CODE_W-1:0] ilim_code,
  input logic [CODE_W-1:0] ss_code,
  input logic [CNT_W-1:0]  ovl_cnt
);
  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    ovl_cnt < CNT_W'(TRIP_CYCLES));
  // R1
  cnt_move_chk: assert property (@(posedge clk) disable iff (rst)
    (ovl_cnt != $past(ovl_cnt)) |-> $past(cyc_start));
  // R7
  olp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    olp_fault |=> olp_fault);
  // R7
  olp_off_chk: assert property (@(posedge clk) disable iff (rst)
    olp_fault |-> !sw_en);
  // R7
  olp_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(olp_fault) |-> $past(cyc_start && pk_at_lim && clamp_over));
  // R6
  burst_cap_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(burst_mode) && !$past(rst)) |-> (ilim_code <= CODE_W'(BURST_CODE)));
  // R5
  ramp_seed_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sw_en) |-> (ss_code == CODE_W'(SS_MIN_CODE)));
endmodule

bind ovr_guard ovr_guard_chk #(
  .CNT_W(CNT_W), .CODE_W(CODE_W), .TRIP_CYCLES(TRIP_CYCLES),
  .BURST_CODE(BURST_CODE), .SS_MIN_CODE(SS_MIN_CODE)
) chk_i (
  .clk(clk), .rst(rst), .cyc_start(cyc_start), .pk_at_lim(pk_at_lim),
  .burst_mode(burst_mode), .clamp_over(clamp_over), .sw_en(sw_en),
  .olp_fault(olp_fault), .ilim_code(ilim_code), .ss_code(ss_code),
  .ovl_cnt(ovl_cnt)
);

// File: tb/ovr_guard_tb_top.sv
module ovr_guard_tb_top;
  localparam int TRIP = 6;
  localparam int DIV  = 4;
  localparam int RT   = 5;
  localparam int SMIN = 16;
  localparam int SINC = 64;
  localparam int FULL = 255;
  localparam int BURST_EXP = 255 * 85 / 400;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc_start = 1'b0, pk_at_lim = 1'b0, burst_mode = 1'b0, clamp_over = 1'b0;
  logic sw_en, olp_fault;
  logic [7:0] ilim_code;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ovr_guard #(
    .TRIP_CYCLES(TRIP), .TICK_DIV(DIV), .RESTART_TICKS(RT), .CODE_W(8),
    .SS_MIN_CODE(SMIN), .SS_INC(SINC), .SS_TICKS_PER_STEP(1),
    .FULL_MA(400), .BURST_MA(85)
  ) dut_i (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .pk_at_lim(pk_at_lim),
    .burst_mode(burst_mode), .clamp_over(clamp_over), .sw_en(sw_en),
    .ilim_code(ilim_code), .olp_fault(olp_fault)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic strobe(input logic pk, input logic cl);
    @(negedge clk);
    cyc_start = 1'b1; pk_at_lim = pk; clamp_over = cl;
    @(negedge clk);
    cyc_start = 1'b0; pk_at_lim = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cyc_start = 1'b0; pk_at_lim = 1'b0; clamp_over = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // called at a negedge where sw_en was just seen at 0; strobes hits meanwhile
  task automatic wait_restart(output int n);
    n = 0;
    while (sw_en === 1'b0 && n < 1000) begin
      n++;
      cyc_start = n[0]; pk_at_lim = 1'b1;
      @(negedge clk);
    end
    cyc_start = 1'b0; pk_at_lim = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int prev, hits, hold_n, exp;
    do_reset();
    // R8 reset state
    check(sw_en === 1'b1, "R8 sw_en", int'(sw_en), 1);
    check(ilim_code === 8'(SMIN), "R8 ilim_code", int'(ilim_code), SMIN);
    check(olp_fault === 1'b0, "R8 olp_fault", int'(olp_fault), 0);

    // R5 ramp sequence from seed to full scale
    prev = SMIN;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (int'(ilim_code) != prev) begin
        exp = (prev + SINC > FULL) ? FULL : prev + SINC;
        check(int'(ilim_code) == exp, "R5 ramp step", int'(ilim_code), exp);
        prev = int'(ilim_code);
      end
    end
    check(ilim_code === 8'(FULL), "R5 ramp end", int'(ilim_code), FULL);

    // R6/R9 burst clamp, one clock latency
    burst_mode = 1'b1;
    check(ilim_code === 8'(FULL), "R9 before edge", int'(ilim_code), FULL);
    @(negedge clk);
    check(ilim_code === 8'(BURST_EXP), "R6 burst code", int'(ilim_code), BURST_EXP);
    burst_mode = 1'b0;
    @(negedge clk);
    check(ilim_code === 8'(FULL), "R9 burst release", int'(ilim_code), FULL);

    // R1/R2/R3/R4 sweep of hits then misses
    for (int k = 0; k < TRIP; k++) begin
      for (int m = 0; m <= TRIP; m++) begin
        for (int i = 0; i < k; i++) begin
          strobe(1'b1, 1'b0);
          check(sw_en === 1'b1, "R1 no early trip", int'(sw_en), 1);
        end
        for (int i = 0; i < m; i++) strobe(1'b0, 1'b0);
        hits = 0;
        while (sw_en === 1'b1 && hits < 2 * TRIP) begin
          strobe(1'b1, 1'b0);
          hits++;
        end
        exp = TRIP - ((k > m) ? k - m : 0);
        check(hits == exp, "R1 R2 R4 hits to trip", hits, exp);
        wait_restart(hold_n);
        check(hold_n >= (RT - 1) * DIV + 1 && hold_n <= RT * DIV,
              "R3 restart wait", hold_n, RT * DIV);
        check(ilim_code === 8'(SMIN), "R5 restart seed", int'(ilim_code), SMIN);
      end
    end

    // R6 burst during a ramp
    burst_mode = 1'b1;
    repeat (TRIP) strobe(1'b1, 1'b0);
    check(sw_en === 1'b0, "R2 trip", int'(sw_en), 0);
    wait_restart(hold_n);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (int'(ilim_code) > BURST_EXP)
        check(1'b0, "R6 burst ramp cap", int'(ilim_code), BURST_EXP);
    end
    check(ilim_code === 8'(BURST_EXP), "R6 burst ramp end", int'(ilim_code), BURST_EXP);
    burst_mode = 1'b0;

    // R7 open-loop fault
    do_reset();
    strobe(1'b0, 1'b1);
    check(olp_fault === 1'b0, "R7 clamp only", int'(olp_fault), 0);
    strobe(1'b1, 1'b0);
    check(olp_fault === 1'b0, "R7 limit only", int'(olp_fault), 0);
    @(negedge clk); clamp_over = 1'b1; pk_at_lim = 1'b1;
    repeat (5) @(negedge clk);
    check(olp_fault === 1'b0, "R7 no strobe", int'(olp_fault), 0);
    clamp_over = 1'b0; pk_at_lim = 1'b0;
    strobe(1'b1, 1'b1);
    check(olp_fault === 1'b1, "R7 set", int'(olp_fault), 1);
    check(sw_en === 1'b0, "R7 switching off", int'(sw_en), 0);
    for (int i = 0; i < 3 * RT * DIV; i++) strobe(1'b0, 1'b0);
    check(olp_fault === 1'b1, "R7 stays latched", int'(olp_fault), 1);
    check(sw_en === 1'b0, "R7 no restart", int'(sw_en), 0);
    do_reset();
    check(olp_fault === 1'b0, "R8 fault cleared", int'(olp_fault), 0);
    check(sw_en === 1'b1, "R8 sw_en after fault", int'(sw_en), 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule